// File: doc/BRIEF.md
# Sampling Tap Drift Corrector

This block holds the sampling-clock tap position of a high-speed SD/eMMC receiver. It moves that position after each command, using the correction requests that a sampling comparator raises. A tuning engine loads the starting tap. After that, every single-cycle evaluate strobe consumes one set of request flags. The block then steps the tap around a ring of N positions, leaves it where it is, or raises a one-cycle retune-required pulse so that the host runs a fresh tuning sweep.

There are three ways of handling requests. In automatic mode, only the automatic-correction error flag counts. In normal single-rate modes, the error, up and down request flags are used. In double-data-rate mode, only the command-line up and down comparison bits are used, because the data lines there are sampled against a separate strobe. In that mode the block will not step onto a tap marked in the bad-tap mask. When that happens, it decides from the stored tuning comparison bitmap whether a retune is needed. The tap is also driven to the delay line, halved when the delay line has only four taps.

Top module: `tap_drift_corr`

## Requirements
- R1: While reset is asserted, and right after it, tap_q is 0 and neither retune nor req_clr is high.
- R2: load_en updates tap_q to load_tap on the next clock edge. A strobe in that cycle is ignored: no clear, no retune.
- R3: When auto_en is high on a strobe, only auto_err counts. If it is set, retune and req_clr pulse. The tap never moves, and the manual and command flags have no effect.
- R4: In normal mode (ddr_mode low) the request flags are served in this order: req_err, then req_up, then req_dn. An error raises retune and leaves the tap unchanged. The command flags are ignored.
- R5: A normal up request sets the tap to (tap+1) mod N, so N−1 wraps to 0. A normal down request sets it to (tap−1) mod N, so 0 wraps to N−1. N is tap_count.
- R6: If req_err, req_up and req_dn are all low on a manual-mode strobe, nothing happens. If any of them is high, req_clr pulses once, in the cycle after the strobe.
- R7: In ddr_mode only cmd_up and cmd_dn count. If neither is set, the tap holds and there is no retune. If both are set, retune pulses and the tap holds.
- R8: In ddr_mode, cmd_up alone gives a candidate tap of (tap+1) mod N and an opposite tap of (tap−1) mod N. cmd_dn alone swaps the two. If bit [candidate] of bad_mask is 0, the tap moves to the candidate.
- R9: If bit [candidate] of bad_mask is 1, the tap holds. Retune then pulses only when bit [opposite] of cmp_map is 1.
- R10: In four_tap mode, dly_code is tap_q shifted right by one. Otherwise dly_code equals tap_q.
- R11: Without a strobe the tap holds and no pulse appears. retune and req_clr are single-cycle pulses, registered on the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_count | input | 4 | Number of taps N in the ring (2..MAX_TAPS) |
| four_tap | input | 1 | Delay line has half the tap resolution |
| ddr_mode | input | 1 | Double-data-rate mode: use command comparison only |
| auto_en | input | 1 | Automatic correction active |
| load_en | input | 1 | Load a new tap from the tuning result |
| load_tap | input | 3 | Tap value to load |
| eval | input | 1 | Single-cycle strobe: consume the current request flags |
| auto_err | input | 1 | Automatic-correction error flag |
| req_err | input | 1 | Normal-mode error request |
| req_up | input | 1 | Normal-mode tap-up request |
| req_dn | input | 1 | Normal-mode tap-down request |
| cmd_up | input | 1 | Command-line comparison asks for a later tap |
| cmd_dn | input | 1 | Command-line comparison asks for an earlier tap |
| bad_mask | input | 8 | Taps that must not be entered in ddr_mode |
| cmp_map | input | 8 | Stored tuning comparison bitmap, bit per tap |
| tap_q | output | 3 | Current tap position |
| dly_code | output | 3 | Value driven to the delay line |
| retune | output | 1 | Retune-required pulse |
| req_clr | output | 1 | Request status consumed and cleared |

## Verification
The bench builds the block with its default of eight taps. It then varies the ring size N at run time, from 2 to 8. This brings both wrap points within reach for every ring size, along with every starting tap and every combination of the three request flags and the two command flags. Each ddr case is run against two bad-tap masks, one with pairs of adjacent bad taps and one with alternating bad taps. Three comparison bitmaps let retune be reached or suppressed on the refused step.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // outcome of one evaluate strobe
  typedef struct packed {
    logic move;    // take the new tap
    logic retune;  // raise retune-required
    logic clr;     // request status consumed
  } tdc_act_t;
endpackage

// File: rtl/tdc_ring_nbr.sv
module tdc_ring_nbr #(
  parameter int TAP_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [TAP_W-1:0] tap,
  input  logic [CNT_W-1:0] cnt,
  output logic [TAP_W-1:0] plus,
  output logic [TAP_W-1:0] minus
);
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] tap_ext;

  always_comb begin
    last    = cnt - 1'b1;
    tap_ext = CNT_W'(tap);
    plus    = (tap_ext == last) ? '0 : tap + 1'b1;
    minus   = (tap == '0) ? TAP_W'(last) : tap - 1'b1;
  end
endmodule

// File: rtl/tdc_decide.sv
module tdc_decide
  import tdc_pkg::*;
#(
  parameter int MAX_TAPS = 8,
  parameter int TAP_W    = 3
) (
  input  logic                ddr_mode,
  input  logic                auto_en,
  input  logic                auto_err,
  input  logic                req_err,
  input  logic                req_up,
  input  logic                req_dn,
  input  logic                cmd_up,
  input  logic                cmd_dn,
  input  logic [MAX_TAPS-1:0] bad_mask,
  input  logic [MAX_TAPS-1:0] cmp_map,
  input  logic [TAP_W-1:0]    plus,
  input  logic [TAP_W-1:0]    minus,
  output tdc_act_t            act,
  output logic [TAP_W-1:0]    new_tap
);
  logic             any_req;
  logic [TAP_W-1:0] cand;
  logic [TAP_W-1:0] opp;

  always_comb begin
    act     = '0;
    new_tap = plus;
    any_req = req_err | req_up | req_dn;
    cand    = cmd_up ? plus : minus;
    opp     = cmd_up ? minus : plus;
    if (auto_en) begin
      act.retune = auto_err;
      act.clr    = auto_err;
    end else if (any_req) begin
      act.clr = 1'b1;
      if (ddr_mode) begin
        if (cmd_up && cmd_dn) begin
          act.retune = 1'b1;
        end else if (cmd_up || cmd_dn) begin
          if (bad_mask[cand]) begin
            act.retune = cmp_map[opp];
          end else begin
            act.move = 1'b1;
            new_tap  = cand;
          end
        end
      end else begin
        if (req_err) begin
          act.retune = 1'b1;
        end else if (req_up) begin
          act.move = 1'b1;
          new_tap  = plus;
        end else begin
          act.move = 1'b1;
          new_tap  = minus;
        end
      end
    end
  end
endmodule

// File: rtl/tdc_dly_map.sv
module tdc_dly_map #(
  parameter int TAP_W = 3
) (
  input  logic             four_tap,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] code
);
  generate
    if (TAP_W > 1) begin : g_wide
      always_comb code = four_tap ? {1'b0, tap[TAP_W-1:1]} : tap;
    end else begin : g_narrow
      always_comb code = four_tap ? 1'b0 : tap;
    end
  endgenerate
endmodule

// File: rtl/tap_drift_corr.sv
module tap_drift_corr
  import tdc_pkg::*;
#(
  parameter int MAX_TAPS = 8,
  localparam int TAP_W   = (MAX_TAPS > 2) ? $clog2(MAX_TAPS) : 1,
  localparam int CNT_W   = TAP_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    tap_count,
  input  logic                four_tap,
  input  logic                ddr_mode,
  input  logic                auto_en,
  input  logic                load_en,
  input  logic [TAP_W-1:0]    load_tap,
  input  logic                eval,
  input  logic                auto_err,
  input  logic                req_err,
  input  logic                req_up,
  input  logic                req_dn,
  input  logic                cmd_up,
  input  logic                cmd_dn,
  input  logic [MAX_TAPS-1:0] bad_mask,
  input  logic [MAX_TAPS-1:0] cmp_map,
  output logic [TAP_W-1:0]    tap_q,
  output logic [TAP_W-1:0]    dly_code,
  output logic                retune,
  output logic                req_clr
);
  logic [TAP_W-1:0] plus, minus, new_tap;
  tdc_act_t         act;
  logic [TAP_W-1:0] tap_d;
  logic             tap_en;
  logic             retune_d, clr_d;

  tdc_ring_nbr #(.TAP_W(TAP_W), .CNT_W(CNT_W)) u_nbr (
    .tap(tap_q), .cnt(tap_count), .plus(plus), .minus(minus)
  );

  tdc_decide #(.MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_dec (
    .ddr_mode(ddr_mode), .auto_en(auto_en), .auto_err(auto_err),
    .req_err(req_err), .req_up(req_up), .req_dn(req_dn),
    .cmd_up(cmd_up), .cmd_dn(cmd_dn), .bad_mask(bad_mask),
    .cmp_map(cmp_map), .plus(plus), .minus(minus),
    .act(act), .new_tap(new_tap)
  );

  tdc_dly_map #(.TAP_W(TAP_W)) u_map (
    .four_tap(four_tap), .tap(tap_q), .code(dly_code)
  );

  // next state: load beats evaluate
  always_comb begin
    tap_en   = 1'b0;
    tap_d    = tap_q;
    retune_d = 1'b0;
    clr_d    = 1'b0;
    if (load_en) begin
      tap_en = 1'b1;
      tap_d  = load_tap;
    end else if (eval) begin
      tap_en   = act.move;
      tap_d    = new_tap;
      retune_d = act.retune;
      clr_d    = act.clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q   <= '0;
      retune  <= 1'b0;
      req_clr <= 1'b0;
    end else begin
      if (tap_en) tap_q <= tap_d;
      retune  <= retune_d;
      req_clr <= clr_d;
    end
  end
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int MAX_TAPS = 8,
  parameter int TAP_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ddr_mode,
  input logic             auto_en,
  input logic             load_en,
  input logic             eval,
  input logic             req_err,
  input logic             req_up,
  input logic             req_dn,
  input logic             cmd_up,
  input logic             cmd_dn,
  input logic [TAP_W-1:0] tap_q,
  input logic             retune,
  input logic             req_clr
);
  a_r11_retune_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
    retune |-> $past(eval));

  a_r6_clear_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |-> $past(eval));

  a_r4_retune_has_clear: assert property (@(posedge clk) disable iff (!rst_n)
    retune |-> req_clr);

  a_r3_auto_holds_tap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eval && auto_en && !load_en) |-> $stable(tap_q));

  a_r7_both_cmd_retune: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eval && !load_en && !auto_en && ddr_mode && (req_err || req_up || req_dn)
          && cmd_up && cmd_dn) |-> (retune && $stable(tap_q)));

  a_r2_tap_moves_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_q) |-> $past(eval || load_en));
endmodule

bind tap_drift_corr tdc_checker #(.MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .auto_en(auto_en),
  .load_en(load_en), .eval(eval), .req_err(req_err), .req_up(req_up),
  .req_dn(req_dn), .cmd_up(cmd_up), .cmd_dn(cmd_dn), .tap_q(tap_q),
  .retune(retune), .req_clr(req_clr)
);

// File: tb/sim_tap_drift_corr.sv
module sim_tap_drift_corr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tap_count;
  logic       four_tap, ddr_mode, auto_en, load_en, eval;
  logic [2:0] load_tap;
  logic       auto_err, req_err, req_up, req_dn, cmd_up, cmd_dn;
  logic [7:0] bad_mask, cmp_map;
  logic [2:0] tap_q, dly_code;
  logic       retune, req_clr;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tap_drift_corr u0 (
    .clk(clk), .rst_n(rst_n), .tap_count(tap_count), .four_tap(four_tap),
    .ddr_mode(ddr_mode), .auto_en(auto_en), .load_en(load_en),
    .load_tap(load_tap), .eval(eval), .auto_err(auto_err),
    .req_err(req_err), .req_up(req_up), .req_dn(req_dn),
    .cmd_up(cmd_up), .cmd_dn(cmd_dn), .bad_mask(bad_mask),
    .cmp_map(cmp_map), .tap_q(tap_q), .dly_code(dly_code),
    .retune(retune), .req_clr(req_clr)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    load_en = 0; eval = 0; auto_err = 0; req_err = 0; req_up = 0;
    req_dn = 0; cmd_up = 0; cmd_dn = 0;
  endtask

  initial begin
    byte unsigned masks [2] = '{8'hCC, 8'hAA};
    byte unsigned cmps  [3] = '{8'h00, 8'hFF, 8'h5A};
    rst_n = 0; tap_count = 4'd8; four_tap = 0; ddr_mode = 0; auto_en = 0;
    load_tap = 0; bad_mask = 0; cmp_map = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 tap in reset", tap_q, 0);
    chk("R1 retune in reset", retune, 0);
    chk("R1 clr in reset", req_clr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tap after reset", tap_q, 0);
    chk("R1 retune after reset", retune, 0);

    // R11: flags without strobe do nothing
    req_up = 1; req_err = 1; cmd_up = 1;
    repeat (2) @(negedge clk);
    chk("R11 no strobe tap", tap_q, 0);
    chk("R11 no strobe retune", retune, 0);
    chk("R11 no strobe clr", req_clr, 0);
    // R11: pulse lasts one cycle
    eval = 1; req_up = 0;
    @(negedge clk);
    eval = 0;
    chk("R11 pulse retune", retune, 1);
    @(negedge clk);
    chk("R11 pulse ends retune", retune, 0);
    chk("R11 pulse ends clr", req_clr, 0);
    // R2: load beats strobe
    req_err = 0; req_up = 1; load_en = 1; load_tap = 3'd5; eval = 1;
    @(negedge clk);
    idle_inputs();
    chk("R2 load value", tap_q, 5);
    chk("R2 load no clr", req_clr, 0);

    for (int n = 2; n <= 8; n++) begin
      tap_count = 4'(n);
      for (int t = 0; t < n; t++) begin
        for (int m = 0; m < 3; m++) begin
          for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 4; c++) begin
              for (int b = 0; b < 2; b++) begin
                for (int k = 0; k < 3; k++) begin
                  int pl, mi, cand, opp, et, ert, ecl;
                  string tag;
                  @(negedge clk);
                  idle_inputs();
                  load_en = 1; load_tap = 3'(t);
                  @(negedge clk);
                  chk("R2 load", tap_q, t);
                  load_en = 0;
                  ddr_mode = (m == 1); auto_en = (m == 2);
                  req_err = r[2]; req_up = r[1]; req_dn = r[0];
                  cmd_up = c[1]; cmd_dn = c[0]; auto_err = c[0];
                  bad_mask = masks[b]; cmp_map = cmps[k];
                  four_tap = ((t + r + k) % 2) == 1;
                  eval = 1;
                  pl = (t + 1) % n; mi = (t + n - 1) % n;
                  et = t; ert = 0; ecl = 0;
                  if (m == 2) begin
                    tag = "R3"; ert = c[0]; ecl = c[0];
                  end else if (r == 0) begin
                    tag = "R6";
                  end else if (m == 1) begin
                    ecl = 1;
                    if (c == 3) begin tag = "R7"; ert = 1; end
                    else if (c == 0) tag = "R7";
                    else begin
                      cand = c[1] ? pl : mi; opp = c[1] ? mi : pl;
                      if (masks[b][cand]) begin tag = "R9"; ert = cmps[k][opp]; end
                      else begin tag = "R8"; et = cand; end
                    end
                  end else begin
                    ecl = 1;
                    if (r[2]) begin tag = "R4"; ert = 1; end
                    else if (r[1]) begin tag = "R5"; et = pl; end
                    else begin tag = "R5"; et = mi; end
                  end
                  @(negedge clk);
                  eval = 0;
                  chk({tag, " tap"}, tap_q, et);
                  chk({tag, " retune"}, retune, ert);
                  chk({"R6 clear ", tag}, req_clr, ecl);
                  chk("R10 delay code", dly_code, four_tap ? (et >> 1) : et);
                end
              end
            end
          end
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule